// File: doc/BRIEF.md
# Memory-Mapped Configurable I/O Port

This block is the register bank and pad steering logic for one 8-bit I/O port. A microcontroller reaches it over a simple read/write bus. An address decoder outside the block asserts a chip select when the bus address falls in the block's 256-byte window, and the low address byte is passed in as the register offset. Writes are captured on the clock edge. Reads return data combinationally.

Each pin is steered in one of three ways. A pin that configuration has handed to programmable logic follows the logic array's output and enable. Any other pin either drives a latched address bit (address-out mode) or acts as a software I/O pin, whose level comes from an output latch and whose enable comes from a direction bit. An open-drain control can be set for each bit, and it releases the line wherever a 1 would be driven. Software can read back the sampled pin levels, the output latch, the configuration registers, the ownership map and the macrocell outputs.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the mode, direction, output latch, open-drain and address latch registers all hold 0. With no pin owned by logic, every pad therefore shows pad_out_o=0x00, pad_oe_o=0xFF and pad_od_o=0x00.
- R2: A register write takes effect at the rising clock edge only when cs_i and wr_i are both high. Without that pair the registers keep their values.
- R3: The mode register (offset 0x02, 1 = software I/O, 0 = address-out), the output latch (0x04), the direction register (0x06, 1 = output) and the open-drain register (0x08, 1 = open drain) read back the value last written.
- R4: Offset 0x0A reads pld_own_i (1 = pin owned by programmable logic). A write to 0x0A changes no register and does not change what 0x0A reads.
- R5: Offset 0x00 returns the pin levels sampled at the previous rising edge, with bits in address-out mode (mode bit 0) reading 0. A change on pin_in_i becomes visible one edge later.
- R6: Offset 0x0C returns mcell_i in the same cycle.
- R7: Any offset other than 0x00, 0x02, 0x04, 0x06, 0x08, 0x0A or 0x0C reads 0x00. rdata_o is 0x00 whenever cs_i and rd_i are not both high.
- R8: For an owned pin, pad_out_o and pad_oe_o follow pld_out_i and pld_oe_i, whatever the mode, latch and direction bits are.
- R9: The address latch captures adr_i at a rising edge where ale_i is high and holds otherwise. A non-owned pin in address-out mode drives its latch bit with the enable set.
- R10: A non-owned pin in software I/O mode drives its output-latch bit, with the enable equal to its direction bit.
- R11: For a pin whose open-drain bit is 1, pad_od_o is 1, and a driven 1 turns into pad_oe_o=0 while a driven 0 stays enabled. Ownership does not change this.

Ports: offsets and data are 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Window chip select from the base-address decoder |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| offs_i | input | 8 | Register offset within the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pin_in_i | input | 8 | Pin levels from the pads |
| ale_i | input | 1 | Address latch enable |
| adr_i | input | 8 | Address bits to latch for address-out mode |
| pld_own_i | input | 8 | Pin ownership by programmable logic |
| pld_out_i | input | 8 | Logic-array output value per pin |
| pld_oe_i | input | 8 | Logic-array output enable per pin |
| mcell_i | input | 8 | Macrocell outputs for read-back |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| pad_od_o | output | 8 | Pad open-drain select |

## Verification
Reads of stored registers, ownership and macrocells are combinational, so the bench samples rdata_o 1 ns after it raises the read strobe, away from any edge. A write or an address-latch capture is visible one rising edge after it is driven. The bench drives these on a falling edge and checks after the next falling edge. The data-in path has one sampling register: its check reads immediately after a pin change, expecting the old value, and reads again one edge later, expecting the new one. Pad outputs are combinational from stored state and inputs, and they are checked 1 ns after the inputs or the last register update settle.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;

    localparam int OFFS_W = 8;

    localparam logic [OFFS_W-1:0] OFF_DIN   = 8'h00;
    localparam logic [OFFS_W-1:0] OFF_MODE  = 8'h02;
    localparam logic [OFFS_W-1:0] OFF_DOUT  = 8'h04;
    localparam logic [OFFS_W-1:0] OFF_DIR   = 8'h06;
    localparam logic [OFFS_W-1:0] OFF_OD    = 8'h08;
    localparam logic [OFFS_W-1:0] OFF_OWN   = 8'h0A;
    localparam logic [OFFS_W-1:0] OFF_MCELL = 8'h0C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIN,
        SEL_MODE,
        SEL_DOUT,
        SEL_DIR,
        SEL_OD,
        SEL_OWN,
        SEL_MCELL
    } reg_sel_e;

    function automatic reg_sel_e decode_offs(input logic [OFFS_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_DIN:   s = SEL_DIN;
            OFF_MODE:  s = SEL_MODE;
            OFF_DOUT:  s = SEL_DOUT;
            OFF_DIR:   s = SEL_DIR;
            OFF_OD:    s = SEL_OD;
            OFF_OWN:   s = SEL_OWN;
            OFF_MCELL: s = SEL_MCELL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cfg_io_regs.sv
module cfg_io_regs
    import cfg_io_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit HAS_OD = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  pin_in_i,
    output logic [WIDTH-1:0]  mode_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  dout_o,
    output logic [WIDTH-1:0]  od_o,
    output logic [WIDTH-1:0]  din_o
);

    typedef struct packed {
        logic [WIDTH-1:0] mode;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] dout;
        logic [WIDTH-1:0] od;
        logic [WIDTH-1:0] din;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e wsel;
    logic     wen;

    assign wsel = decode_offs(offs_i);
    assign wen  = cs_i && wr_i;

    always_comb begin
        regs_d     = regs_q;
        regs_d.din = pin_in_i;
        if (wen) begin
            case (wsel)
                SEL_MODE: regs_d.mode = wdata_i;
                SEL_DOUT: regs_d.dout = wdata_i;
                SEL_DIR:  regs_d.dir  = wdata_i;
                SEL_OD: begin
                    if (HAS_OD) begin
                        regs_d.od = wdata_i;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode_o = regs_q.mode;
    assign dir_o  = regs_q.dir;
    assign dout_o = regs_q.dout;
    assign od_o   = regs_q.od;
    assign din_o  = regs_q.din;

    // R2: without a chip-selected write, the configuration registers hold
    a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cs_i && wr_i) |=> ($stable(mode_o) && $stable(dir_o) && $stable(dout_o) && $stable(od_o)));

    // R3: a write to the mode offset lands in the mode register on the next edge
    a_r3_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && wr_i && offs_i == OFF_MODE) |=> (mode_o == $past(wdata_i)));

    // R4: a write to the ownership offset leaves every register unchanged
    a_r4_own_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && wr_i && offs_i == OFF_OWN) |=> ($stable(mode_o) && $stable(dir_o) && $stable(dout_o) && $stable(od_o)));

    // R5: data-in holds the pin levels from the previous edge
    a_r5_din_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (din_o == $past(pin_in_i)));

endmodule

// File: rtl/cfg_io_alatch.sv
module cfg_io_alatch #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ale_i,
    input  logic [WIDTH-1:0] adr_i,
    output logic [WIDTH-1:0] lat_o
);

    logic [WIDTH-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (ale_i) begin
            lat_d = adr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign lat_o = lat_q;

    // R9: the latch holds while the enable is low
    a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ale_i |=> $stable(lat_o));

    // R9: the latch takes the address presented with the enable
    a_r9_latch_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_i |=> (lat_o == $past(adr_i)));

endmodule

// File: rtl/cfg_io_pads.sv
module cfg_io_pads #(
    parameter int WIDTH  = 8,
    parameter bit HAS_OD = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] own_i,
    input  logic [WIDTH-1:0] pld_out_i,
    input  logic [WIDTH-1:0] pld_oe_i,
    input  logic [WIDTH-1:0] mode_i,
    input  logic [WIDTH-1:0] lat_i,
    input  logic [WIDTH-1:0] dout_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] od_i,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o,
    output logic [WIDTH-1:0] pad_od_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic val, en, od;

        always_comb begin
            if (own_i[i]) begin
                val = pld_out_i[i];
                en  = pld_oe_i[i];
            end else if (!mode_i[i]) begin
                val = lat_i[i];
                en  = 1'b1;
            end else begin
                val = dout_i[i];
                en  = dir_i[i];
            end
        end

        if (HAS_OD) begin : g_od
            assign od = od_i[i];
        end else begin : g_cmos
            assign od = 1'b0;
        end

        assign pad_out_o[i] = val;
        assign pad_oe_o[i]  = en && !(od && val);
        assign pad_od_o[i]  = od;

        // R11: an open-drain pin never actively drives a high level
        a_r11_od_no_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pad_od_o[i] && pad_oe_o[i]) |-> !pad_out_o[i]);

        // R8: an owned push-pull pin copies the logic-array enable
        a_r8_owned_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (own_i[i] && !pad_od_o[i]) |-> (pad_oe_o[i] == pld_oe_i[i]));

        // R9: a free pin in address-out mode is always enabled unless released by open drain
        a_r9_addr_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!own_i[i] && !mode_i[i] && !pad_od_o[i]) |-> pad_oe_o[i]);
    end

endmodule

// File: rtl/cfg_io_rdmux.sv
module cfg_io_rdmux
    import cfg_io_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [WIDTH-1:0]  din_i,
    input  logic [WIDTH-1:0]  mode_i,
    input  logic [WIDTH-1:0]  dout_i,
    input  logic [WIDTH-1:0]  dir_i,
    input  logic [WIDTH-1:0]  od_i,
    input  logic [WIDTH-1:0]  own_i,
    input  logic [WIDTH-1:0]  mcell_i,
    output logic [WIDTH-1:0]  rdata_o
);

    reg_sel_e rsel;

    assign rsel = decode_offs(offs_i);

    always_comb begin
        rdata_o = '0;
        if (cs_i && rd_i) begin
            case (rsel)
                SEL_DIN:   rdata_o = din_i & mode_i;
                SEL_MODE:  rdata_o = mode_i;
                SEL_DOUT:  rdata_o = dout_i;
                SEL_DIR:   rdata_o = dir_i;
                SEL_OD:    rdata_o = od_i;
                SEL_OWN:   rdata_o = own_i;
                SEL_MCELL: rdata_o = mcell_i;
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import cfg_io_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit HAS_OD = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  rdata_o,
    input  logic [WIDTH-1:0]  pin_in_i,
    input  logic              ale_i,
    input  logic [WIDTH-1:0]  adr_i,
    input  logic [WIDTH-1:0]  pld_own_i,
    input  logic [WIDTH-1:0]  pld_out_i,
    input  logic [WIDTH-1:0]  pld_oe_i,
    input  logic [WIDTH-1:0]  mcell_i,
    output logic [WIDTH-1:0]  pad_out_o,
    output logic [WIDTH-1:0]  pad_oe_o,
    output logic [WIDTH-1:0]  pad_od_o
);

    logic [WIDTH-1:0] mode_q, dir_q, dout_q, od_q, din_q, lat_q;

    cfg_io_regs #(.WIDTH(WIDTH), .HAS_OD(HAS_OD)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_i     (cs_i),
        .wr_i     (wr_i),
        .offs_i   (offs_i),
        .wdata_i  (wdata_i),
        .pin_in_i (pin_in_i),
        .mode_o   (mode_q),
        .dir_o    (dir_q),
        .dout_o   (dout_q),
        .od_o     (od_q),
        .din_o    (din_q)
    );

    cfg_io_alatch #(.WIDTH(WIDTH)) u_alatch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ale_i  (ale_i),
        .adr_i  (adr_i),
        .lat_o  (lat_q)
    );

    cfg_io_pads #(.WIDTH(WIDTH), .HAS_OD(HAS_OD)) u_pads (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .own_i     (pld_own_i),
        .pld_out_i (pld_out_i),
        .pld_oe_i  (pld_oe_i),
        .mode_i    (mode_q),
        .lat_i     (lat_q),
        .dout_i    (dout_q),
        .dir_i     (dir_q),
        .od_i      (od_q),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o),
        .pad_od_o  (pad_od_o)
    );

    cfg_io_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .cs_i    (cs_i),
        .rd_i    (rd_i),
        .offs_i  (offs_i),
        .din_i   (din_q),
        .mode_i  (mode_q),
        .dout_i  (dout_q),
        .dir_i   (dir_q),
        .od_i    (od_q),
        .own_i   (pld_own_i),
        .mcell_i (mcell_i),
        .rdata_o (rdata_o)
    );

    // R7: the read bus is quiet unless a chip-selected read is in progress
    a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cs_i && rd_i) |-> (rdata_o == '0));

    // R4: the ownership offset mirrors the ownership inputs
    a_r4_own_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && rd_i && offs_i == OFF_OWN) |-> (rdata_o == pld_own_i));

    // R6: the macrocell offset mirrors the macrocell outputs
    a_r6_mcell_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && rd_i && offs_i == OFF_MCELL) |-> (rdata_o == mcell_i));

endmodule

// File: tb/cfg_io_port_test.sv
module cfg_io_port_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, ale = 1'b0;
    logic [7:0] offs = '0, wdata = '0, pin_in = '0, adr = '0;
    logic [7:0] own = '0, pout = '0, poe = '0, mcell = '0;
    logic [7:0] rdata, pad_out, pad_oe, pad_od;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_io_port uut (
        .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .rd_i(rd), .wr_i(wr),
        .offs_i(offs), .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pin_in),
        .ale_i(ale), .adr_i(adr), .pld_own_i(own), .pld_out_i(pout),
        .pld_oe_i(poe), .mcell_i(mcell), .pad_out_o(pad_out),
        .pad_oe_o(pad_oe), .pad_od_o(pad_od)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] o, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; offs = o; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] o, output logic [7:0] d);
        cs = 1'b1; rd = 1'b1; offs = o;
        #1;
        d = rdata;
        cs = 1'b0; rd = 1'b0;
        #1;
    endtask

    task automatic pads(input string tag, input logic [7:0] eo, input logic [7:0] ee, input logic [7:0] ed);
        #1;
        chk({tag, " pad_out"}, pad_out, eo);
        chk({tag, " pad_oe"}, pad_oe, ee);
        chk({tag, " pad_od"}, pad_od, ed);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_rd(8'h02, d); chk("R1 mode", d, 8'h00);
        bus_rd(8'h04, d); chk("R1 dout", d, 8'h00);
        bus_rd(8'h06, d); chk("R1 dir", d, 8'h00);
        bus_rd(8'h08, d); chk("R1 od", d, 8'h00);
        pads("R1", 8'h00, 8'hFF, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bus_wr(8'h02, 8'hA5); bus_wr(8'h04, 8'h3C);
        bus_wr(8'h06, 8'h96); bus_wr(8'h08, 8'h41);
        bus_rd(8'h02, d); chk("R3 mode", d, 8'hA5);
        bus_rd(8'h04, d); chk("R3 dout", d, 8'h3C);
        bus_rd(8'h06, d); chk("R3 dir", d, 8'h96);
        bus_rd(8'h08, d); chk("R3 od", d, 8'h41);
        // R2: strobe without chip select, then chip select without strobe
        @(negedge clk); cs = 1'b0; wr = 1'b1; offs = 8'h02; wdata = 8'h00;
        @(negedge clk); wr = 1'b0; cs = 1'b1;
        @(negedge clk); cs = 1'b0;
        bus_rd(8'h02, d); chk("R2 no write", d, 8'hA5);
    endtask

    task automatic t_own();
        logic [7:0] d;
        bus_wr(8'h02, 8'h5A);
        own = 8'h3C;
        bus_rd(8'h0A, d); chk("R4 own read", d, 8'h3C);
        bus_wr(8'h0A, 8'hFF);
        bus_rd(8'h0A, d); chk("R4 own after write", d, 8'h3C);
        bus_rd(8'h02, d); chk("R4 mode untouched", d, 8'h5A);
        own = 8'h00;
    endtask

    task automatic t_din();
        logic [7:0] d;
        bus_wr(8'h02, 8'hF0);
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk);
        bus_rd(8'h00, d); chk("R5 masked sample", d, 8'h50);
        @(negedge clk); pin_in = 8'hFF;
        bus_rd(8'h00, d); chk("R5 before edge", d, 8'h50);
        @(negedge clk);
        bus_rd(8'h00, d); chk("R5 after edge", d, 8'hF0);
    endtask

    task automatic t_mcell_unmapped();
        logic [7:0] d;
        mcell = 8'h96;
        bus_rd(8'h0C, d); chk("R6 mcell", d, 8'h96);
        mcell = 8'h69;
        bus_rd(8'h0C, d); chk("R6 mcell change", d, 8'h69);
        bus_rd(8'h01, d); chk("R7 offs 01", d, 8'h00);
        bus_rd(8'h0E, d); chk("R7 offs 0E", d, 8'h00);
        bus_rd(8'hFF, d); chk("R7 offs FF", d, 8'h00);
        cs = 1'b1; offs = 8'h02; #1;
        chk("R7 no strobe", rdata, 8'h00);
        cs = 1'b0; #1;
    endtask

    task automatic t_addr();
        bus_wr(8'h02, 8'h00); bus_wr(8'h08, 8'h00);
        @(negedge clk); adr = 8'hC3; ale = 1'b1;
        @(negedge clk); ale = 1'b0; adr = 8'h11;
        pads("R9 address-out", 8'hC3, 8'hFF, 8'h00);
        @(negedge clk);
        pads("R9 hold", 8'hC3, 8'hFF, 8'h00);
    endtask

    task automatic t_mcu();
        bus_wr(8'h02, 8'hFF); bus_wr(8'h04, 8'h0F); bus_wr(8'h06, 8'h33);
        pads("R10 software I/O", 8'h0F, 8'h33, 8'h00);
    endtask

    task automatic t_od();
        bus_wr(8'h06, 8'hFF); bus_wr(8'h08, 8'h0F);
        pads("R11 driven ones released", 8'h0F, 8'hF0, 8'h0F);
        bus_wr(8'h04, 8'h00);
        pads("R11 driven zeros kept", 8'h00, 8'hFF, 8'h0F);
    endtask

    task automatic t_prio();
        bus_wr(8'h08, 8'h00); bus_wr(8'h02, 8'h30);
        bus_wr(8'h04, 8'hFF); bus_wr(8'h06, 8'hFF);
        own = 8'h0F; pout = 8'h05; poe = 8'h03;
        pads("R8 priority", 8'hF5, 8'hF3, 8'h00);
        bus_wr(8'h08, 8'h01);
        pads("R11 owned open drain", 8'hF5, 8'hF2, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_own();
        t_din();
        t_mcell_unmapped();
        t_addr();
        t_mcu();
        t_od();
        t_prio();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule